// File: doc/BRIEF.md
# Write-Once Memory with Deferred Reads

This block is a small synchronization memory in which every location can be written exactly once. Each location carries a presence flag and a data word. A consumer can ask for a location before any producer has written it. That request is not refused. It is parked on a queue that belongs to that location, and it is answered automatically once the value arrives. Producers and consumers can therefore run out of order without polling.

A read of a location that already holds data is answered on the next cycle. A read of an empty location takes a node from a shared pool and appends the requester's tag to that location's pending list. The single legal write stores the word, marks the location full, and then plays back every parked request, oldest first. It issues one tagged response per cycle. A second write to a full location is rejected with an error pulse. The only way to empty the memory is the global reset.

Top module: `istruct_mem`

## Requirements
- R1: After reset every location is empty, no response or error is presented, both request ports are ready, and all 16 pool nodes are free.
- R2: A read accepted on a full location presents rsp_valid in the following cycle, with the requester's tag and the stored word.
- R3: A read accepted on an empty location produces no response until that location is written.
- R4: A write accepted on an empty location that has parked reads presents their responses in arrival order, one per consecutive cycle, starting in the second cycle after the write is accepted. Every response carries the written word.
- R5: While parked reads are being played back, wr_ready and rd_ready stay low. Both return high in the cycle in which the last parked response is presented.
- R6: A write accepted on a full location raises wr_err for exactly one cycle, in the cycle after acceptance. The stored word is left unchanged.
- R7: The pool holds 16 nodes. While no node is free, rd_ready is low for every read, including reads of full locations. Nodes are returned to the pool as their responses are played back.
- R8: Parked lists are kept per location: a write releases only the reads parked on its own address.
- R9: A write to an empty location with no parked reads produces no response, and wr_ready stays high.
- R10: When wr_valid is high in a cycle, rd_ready is low in that cycle, so the write is taken first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears every presence flag and the pool |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | ADDR_W (4) | Write location |
| wr_data | input | DATA_W (16) | Word to store |
| wr_err | output | 1 | One-cycle pulse after a write to a full location |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rd_addr | input | ADDR_W (4) | Read location |
| rd_tag | input | TAG_W (4) | Requester tag returned with the response |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_tag | output | TAG_W (4) | Tag of the answered read |
| rsp_data | output | DATA_W (16) | Word for the answered read |

## Verification
Most internal faults show up at the response port within a few cycles of the write that should release them.

- A broken link between pool nodes causes a dropped, repeated or reordered tag during playback.
- A wrong tail pointer causes playback to end early, so ready returns before all parked tags have been answered.
- A lost free-pool bit appears only later: rd_ready drops before the sixteenth outstanding read, or never returns after a full drain.
- A presence flag that is set or cleared wrongly shows up on the next read of that address. Either the one-cycle hit response is missing, or it appears when the read should have been parked, or a second write fails to raise the error pulse.

// File: rtl/istr_pkg.sv
package istr_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_REPLAY = 1'b1
  } istr_state_e;
endpackage

// File: rtl/istr_free_pool.sv
// Bitmap of free list nodes; lowest free index is handed out first.
module istr_free_pool #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          rel_en,
  input  logic [IW-1:0] rel_idx,
  output logic [IW-1:0] alloc_idx,
  output logic [N-1:0]  free_map
);
  logic [N-1:0] free_q, free_d;

  always_comb begin
    alloc_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_idx = IW'(i);
    end
  end

  always_comb begin
    free_d = free_q;
    if (alloc_en) free_d[alloc_idx] = 1'b0;
    if (rel_en)   free_d[rel_idx]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  free_q <= '1;
    else if (alloc_en || rel_en) free_q <= free_d;
  end

  assign free_map = free_q;
endmodule

// File: rtl/istr_node_store.sv
// Tag and successor pointer for every list node.
module istr_node_store #(
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic          lk_en,
  input  logic [IW-1:0] lk_idx,
  input  logic [IW-1:0] lk_next,
  input  logic [IW-1:0] rd_idx,
  output logic [TW-1:0] rd_tag,
  output logic [IW-1:0] rd_next
);
  logic [TW-1:0] tag_q  [N];
  logic [IW-1:0] next_q [N];

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx]  <= wr_tag;
    if (lk_en) next_q[lk_idx] <= lk_next;
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_next = next_q[rd_idx];
endmodule

// File: rtl/istr_loc_table.sv
// Per-location presence flag, word, and pending list head/tail.
module istr_loc_table #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  output logic          a_full,
  output logic          a_pend,
  output logic [IW-1:0] a_head,
  output logic [IW-1:0] a_tail,
  input  logic [AW-1:0] b_addr,
  output logic          b_full,
  output logic          b_pend,
  output logic [IW-1:0] b_tail,
  output logic [DW-1:0] b_data,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [DW-1:0] set_data,
  input  logic          app_en,
  input  logic [AW-1:0] app_addr,
  input  logic [IW-1:0] app_node
);
  logic [DEPTH-1:0] full_q, full_d, pend_q, pend_d;
  logic [DW-1:0]    data_q [DEPTH];
  logic [IW-1:0]    head_q [DEPTH];
  logic [IW-1:0]    tail_q [DEPTH];

  always_comb begin
    full_d = full_q;
    pend_d = pend_q;
    if (set_en) begin
      full_d[set_addr] = 1'b1;
      pend_d[set_addr] = 1'b0;
    end
    if (app_en) pend_d[app_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      pend_q <= '0;
    end else if (set_en || app_en) begin
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) data_q[set_addr] <= set_data;
    if (app_en) begin
      tail_q[app_addr] <= app_node;
      if (!pend_q[app_addr]) head_q[app_addr] <= app_node;
    end
  end

  assign a_full = full_q[a_addr];
  assign a_pend = pend_q[a_addr];
  assign a_head = head_q[a_addr];
  assign a_tail = tail_q[a_addr];
  assign b_full = full_q[b_addr];
  assign b_pend = pend_q[b_addr];
  assign b_tail = tail_q[b_addr];
  assign b_data = data_q[b_addr];
endmodule

// File: rtl/istruct_mem.sv
module istruct_mem
  import istr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int POOL   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IW    = $clog2(POOL);

  istr_state_e   state_q, state_d;
  logic [IW-1:0] cur_q, cur_d, rtail_q, rtail_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rsp_valid_d, err_d;
  logic [TAG_W-1:0]  rsp_tag_d;
  logic [DATA_W-1:0] rsp_data_d;

  logic          a_full, a_pend, b_full, b_pend;
  logic [IW-1:0] a_head, a_tail, b_tail;
  logic [DATA_W-1:0] b_data;
  logic [IW-1:0] alloc_idx, nd_next;
  logic [TAG_W-1:0] nd_tag;
  logic [POOL-1:0]  free_map;
  logic wr_fire, rd_fire, wr_first, wr_dup, rd_hit, rd_miss, replaying, last;

  assign replaying = (state_q == ST_REPLAY);
  assign wr_ready  = !replaying;
  assign rd_ready  = !replaying && !wr_valid && (|free_map);
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign wr_first  = wr_fire && !a_full;
  assign wr_dup    = wr_fire && a_full;
  assign rd_hit    = rd_fire && b_full;
  assign rd_miss   = rd_fire && !b_full;
  assign last      = (cur_q == rtail_q);

  istr_loc_table #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_loc (
    .clk(clk), .rst_n(rst_n),
    .a_addr(wr_addr), .a_full(a_full), .a_pend(a_pend), .a_head(a_head), .a_tail(a_tail),
    .b_addr(rd_addr), .b_full(b_full), .b_pend(b_pend), .b_tail(b_tail), .b_data(b_data),
    .set_en(wr_first), .set_addr(wr_addr), .set_data(wr_data),
    .app_en(rd_miss), .app_addr(rd_addr), .app_node(alloc_idx)
  );

  istr_free_pool #(.N(POOL), .IW(IW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(rd_miss), .rel_en(replaying), .rel_idx(cur_q),
    .alloc_idx(alloc_idx), .free_map(free_map)
  );

  istr_node_store #(.N(POOL), .IW(IW), .TW(TAG_W)) u_node (
    .clk(clk),
    .wr_en(rd_miss), .wr_idx(alloc_idx), .wr_tag(rd_tag),
    .lk_en(rd_miss && b_pend), .lk_idx(b_tail), .lk_next(alloc_idx),
    .rd_idx(cur_q), .rd_tag(nd_tag), .rd_next(nd_next)
  );

  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    rtail_d     = rtail_q;
    rdata_d     = rdata_q;
    rsp_valid_d = 1'b0;
    rsp_tag_d   = rsp_tag;
    rsp_data_d  = rsp_data;
    err_d       = wr_dup;
    if (replaying) begin
      rsp_valid_d = 1'b1;
      rsp_tag_d   = nd_tag;
      rsp_data_d  = rdata_q;
      if (last) state_d = ST_IDLE;
      else      cur_d   = nd_next;
    end else begin
      if (wr_first && a_pend) begin
        state_d = ST_REPLAY;
        cur_d   = a_head;
        rtail_d = a_tail;
        rdata_d = wr_data;
      end
      if (rd_hit) begin
        rsp_valid_d = 1'b1;
        rsp_tag_d   = rd_tag;
        rsp_data_d  = b_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_valid_d;
      wr_err    <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) begin
      rsp_tag  <= rsp_tag_d;
      rsp_data <= rsp_data_d;
    end
    if (wr_first || replaying) begin
      cur_q   <= cur_d;
      rtail_q <= rtail_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/istr_chk.sv
module istr_chk #(
  parameter int TW   = 4,
  parameter int POOL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [TW-1:0] rd_tag,
  input logic          rsp_valid,
  input logic [TW-1:0] rsp_tag,
  input logic          wr_err,
  input logic          hit_full,
  input logic [POOL-1:0] free_map
);
  // R2: a hit answers on the next cycle with the same tag
  a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && hit_full) |=> (rsp_valid && rsp_tag == $past(rd_tag)));

  // R3: a response only follows a hit or a playback cycle
  a_r3_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(rd_valid && rd_ready) || $past(!wr_ready)));

  // R4: each playback cycle yields a response
  a_r4_replay_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> rsp_valid);

  // R5: playback only starts after a write request
  a_r5_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ready) |-> $past(wr_valid));

  // R6: error pulse follows an accepted write
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid && wr_ready));

  // R7: no read is taken with the pool empty
  a_r7_pool_guard: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> ($countones(free_map) != 0));
endmodule

bind istruct_mem istr_chk #(.TW(TAG_W), .POOL(POOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .wr_err(wr_err),
  .hit_full(b_full), .free_map(free_map)
);

// File: tb/sim_istruct_mem.sv
module sim_istruct_mem;
  localparam int CLK_P = 10;
  localparam int WD    = 20000;

  logic clk, rst_n;
  logic wr_valid, wr_ready, wr_err, rd_valid, rd_ready, rsp_valid;
  logic [3:0]  wr_addr, rd_addr, rd_tag, rsp_tag;
  logic [15:0] wr_data, rsp_data;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  istruct_mem u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  typedef struct packed {
    logic        is_rd;
    logic [3:0]  addr;
    logic [15:0] val;
    logic        ev;
    logic        ee;
    logic [15:0] ed;
  } vec_t;

  // is_rd, addr, data or tag, expected rsp_valid, expected wr_err, expected word
  localparam vec_t TBL [8] = '{
    '{1'b0, 4'd1,  16'h1111, 1'b0, 1'b0, 16'h0000},  // R9
    '{1'b1, 4'd1,  16'h0003, 1'b1, 1'b0, 16'h1111},  // R2
    '{1'b0, 4'd2,  16'hA5A5, 1'b0, 1'b0, 16'h0000},  // R9
    '{1'b1, 4'd2,  16'h0007, 1'b1, 1'b0, 16'hA5A5},  // R2
    '{1'b0, 4'd1,  16'hBEEF, 1'b0, 1'b1, 16'h0000},  // R6
    '{1'b1, 4'd1,  16'h0009, 1'b1, 1'b0, 16'h1111},  // R6 word kept
    '{1'b0, 4'd15, 16'hFFFF, 1'b0, 1'b0, 16'h0000},  // R9
    '{1'b1, 4'd15, 16'h000F, 1'b1, 1'b0, 16'hFFFF}   // R2
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    while (!wr_ready) step();
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [3:0] t);
    while (!rd_ready) step();
    rd_valid = 1'b1; rd_addr = a; rd_tag = t;
    step();
    rd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; rd_tag = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);

    // Table walk: hits, first writes, duplicate write
    foreach (TBL[i]) begin
      if (TBL[i].is_rd) do_read(TBL[i].addr, TBL[i].val[3:0]);
      else              do_write(TBL[i].addr, TBL[i].val);
      chk($sformatf("R2/R6/R9 vec%0d rsp_valid", i), rsp_valid, TBL[i].ev);
      chk($sformatf("R6 vec%0d wr_err", i), wr_err, TBL[i].ee);
      if (TBL[i].ev) begin
        chk($sformatf("R2 vec%0d rsp_tag", i), rsp_tag, TBL[i].val[3:0]);
        chk($sformatf("R2 vec%0d rsp_data", i), rsp_data, TBL[i].ed);
      end
      if (!TBL[i].is_rd) chk($sformatf("R9 vec%0d wr_ready", i), wr_ready, 1);
      step();
      chk($sformatf("R6 vec%0d err one cycle", i), wr_err, 0);
      chk($sformatf("R9 vec%0d no late rsp", i), rsp_valid, 0);
    end

    // R3 R4 R5: three parked reads on location 4
    for (int t = 1; t <= 3; t++) begin
      do_read(4'd4, 4'(t));
      chk("R3 parked read silent", rsp_valid, 0);
    end
    do_write(4'd4, 16'h4444);
    chk("R4 no rsp at accept", rsp_valid, 0);
    chk("R5 wr_ready low", wr_ready, 0);
    chk("R5 rd_ready low", rd_ready, 0);
    for (int t = 1; t <= 3; t++) begin
      step();
      chk("R4 replay valid", rsp_valid, 1);
      chk("R4 replay tag order", rsp_tag, t);
      chk("R4 replay word", rsp_data, 16'h4444);
      chk("R5 wr_ready during replay", wr_ready, (t == 3) ? 1 : 0);
    end
    step();
    chk("R4 replay ends", rsp_valid, 0);

    // R8: separate lists on locations 5 and 6
    do_read(4'd5, 4'd5);
    do_read(4'd6, 4'd6);
    do_write(4'd6, 16'h6666);
    step();
    chk("R8 only loc6 tag", rsp_tag, 6);
    chk("R8 only loc6 valid", rsp_valid, 1);
    step();
    chk("R8 loc5 still parked", rsp_valid, 0);
    do_write(4'd5, 16'h5555);
    step();
    chk("R8 loc5 released tag", rsp_tag, 5);
    chk("R8 loc5 released word", rsp_data, 16'h5555);
    step();

    // R7: exhaust the pool on location 8
    for (int t = 0; t < 16; t++) do_read(4'd8, 4'(t));
    chk("R7 rd_ready low when pool empty", rd_ready, 0);
    rd_valid = 1'b1; rd_addr = 4'd1; rd_tag = 4'd12;
    step();
    chk("R7 hit blocked while pool empty", rsp_valid, 0);
    rd_valid = 1'b0;
    do_write(4'd8, 16'h8888);
    for (int t = 0; t < 16; t++) begin
      step();
      chk("R7 drain valid", rsp_valid, 1);
      chk("R7 drain tag order", rsp_tag, t);
    end
    chk("R7 pool returned", rd_ready, 1);
    do_read(4'd8, 4'd2);
    chk("R7 hit after drain", rsp_data, 16'h8888);
    step();

    // R10: write wins over a read in the same cycle
    wr_valid = 1'b1; wr_addr = 4'd9; wr_data = 16'h9999;
    rd_valid = 1'b1; rd_addr = 4'd9; rd_tag = 4'd5;
    #1;
    chk("R10 rd_ready low with write", rd_ready, 0);
    step();
    wr_valid = 1'b0;
    chk("R10 read not yet taken", rsp_valid, 0);
    step();
    rd_valid = 1'b0;
    chk("R10 read then hits valid", rsp_valid, 1);
    chk("R10 read then hits word", rsp_data, 16'h9999);
    chk("R10 read then hits tag", rsp_tag, 5);
    step();

    done = 1;
    summary();
  end
endmodule